// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds sixteen general registers for a processor core whose upper registers change with the operating mode. A 5-bit mode register picks which physical copies of registers 8 through 14 the core sees. The fast-interrupt mode has private copies of all seven of those registers. The other privileged modes have private copies of registers 13 and 14 only, and share 8 through 12 with user mode. Registers 0 to 7 and register 15 are one set of storage shared by every mode. Any mode code that is not recognised selects an empty bank. In that bank registers 8 to 14 read as zero and writes to them are dropped.

The core reads through two combinational ports and writes through one port, all in the current mode. A debug port names a mode explicitly. It reads or writes the register as that mode sees it and leaves the current mode unchanged. A privilege output goes high for every mode except those whose two low code bits are zero.

Each mode has its own fixed storage, so a mode change is a single register load. Reads in the next cycle already see the new bank.

Top module: `banked_regfile`

## Requirements
- R1: Asynchronous active-low reset sets the mode to 19 (supervisor) and clears every physical register to zero, so all reads return 0 and `priv` is 1.
- R2: When `mode_wr_en` is high, `mode_in` is loaded into the mode register at the clock edge, and reads in the next cycle use the new bank. When it is low, the mode holds.
- R3: `priv` is 1 exactly when bit 0 or bit 1 of the current mode is 1.
- R4: Registers 0 to 7 and register 15 are one copy shared by all modes, including unrecognised ones.
- R5: Mode codes map to banks as follows: 0 and 16 to user, 1 and 17 to fast interrupt, 2 and 18 to interrupt, 3 and 19 to supervisor, 23 to abort, 27 to undefined. Every other code, including 28 to 31, maps to the empty bank.
- R6: The fast-interrupt bank has private copies of registers 8 to 14.
- R7: The interrupt, supervisor, abort and undefined banks have private copies of registers 13 and 14 only. They share registers 8 to 12 with user mode.
- R8: In the empty bank, registers 8 to 14 read as zero and writes to them change no storage.
- R9: A write-port access stores `wr_data` into register `wr_idx` of the current bank at the clock edge. The read ports are combinational, so a read of that register in the same cycle returns the old value.
- R10: The debug port reads (`dbg_rdata`) and writes (`dbg_we`) register `dbg_idx` of the bank selected by `dbg_mode`, and never changes the mode.
- R11: If the write port and the debug write hit the same physical register in one cycle, the debug data is stored. Writes to different registers are both stored.
- R12: A write issued in the same cycle as a mode change lands in the bank of the mode that was current before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr_en | input | 1 | Load a new mode at the edge |
| mode_in | input | 5 | Next mode code |
| mode_out | output | 5 | Current mode code |
| priv | output | 1 | Current mode is privileged |
| rd_a_idx | input | 4 | Read port A register number |
| rd_a_data | output | WIDTH | Read port A data |
| rd_b_idx | input | 4 | Read port B register number |
| rd_b_data | output | WIDTH | Read port B data |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 4 | Write port register number |
| wr_data | input | WIDTH | Write port data |
| dbg_mode | input | 5 | Mode whose view the debug port uses |
| dbg_idx | input | 4 | Debug register number |
| dbg_we | input | 1 | Debug write enable |
| dbg_wdata | input | WIDTH | Debug write data |
| dbg_rdata | output | WIDTH | Debug read data |

## Verification
Two kinds of overlap can happen in one cycle. In the first, the core write port and a debug write reach the same physical register. This happens with the same mode, and also when two different modes share the register, for example register 9 seen from supervisor and from user. In the second, a core write coincides with a mode change. Both overlaps are driven in directed cycles, and then again at random with the mode drawn from a small set that includes shared, private and empty banks. The reference model applies the core write first, then the debug write, then the mode update. Each read result is compared with the model every cycle, and with fixed expected constants in the directed cases.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int         WIDTH      = 32,
  parameter logic [4:0] RESET_MODE = 5'd19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr_en,
  input  logic [4:0]       mode_in,
  output logic [4:0]       mode_out,
  output logic             priv,
  input  logic [3:0]       rd_a_idx,
  output logic [WIDTH-1:0] rd_a_data,
  input  logic [3:0]       rd_b_idx,
  output logic [WIDTH-1:0] rd_b_data,
  input  logic             wr_en,
  input  logic [3:0]       wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [4:0]       dbg_mode,
  input  logic [3:0]       dbg_idx,
  input  logic             dbg_we,
  input  logic [WIDTH-1:0] dbg_wdata,
  output logic [WIDTH-1:0] dbg_rdata
);
  // slots: 0..15 shared/user view, 16..22 fast-irq r8..r14, 23..30 r13/r14 pairs
  localparam int NSLOT = 31;

  typedef struct packed {
    logic       ok;
    logic [4:0] slot;
  } loc_t;

  logic [WIDTH-1:0] regs [NSLOT];
  logic [4:0]       mode_q;
  loc_t             loc_a, loc_b, loc_w, loc_d;

  function automatic loc_t locate(input logic [4:0] m, input logic [3:0] idx);
    logic [2:0] bk;
    loc_t       l;
    case (m)
      5'd0,  5'd16: bk = 3'd0;
      5'd1,  5'd17: bk = 3'd1;
      5'd2,  5'd18: bk = 3'd2;
      5'd3,  5'd19: bk = 3'd3;
      5'd23:        bk = 3'd4;
      5'd27:        bk = 3'd5;
      default:      bk = 3'd6;
    endcase
    l.ok   = 1'b1;
    l.slot = {1'b0, idx};
    if (idx >= 4'd8 && idx <= 4'd14) begin
      if (bk == 3'd6)
        l.ok = 1'b0;
      else if (bk == 3'd1)
        l.slot = 5'd8 + {1'b0, idx};
      else if (idx >= 4'd13 && bk != 3'd0)
        l.slot = 5'd19 + {1'b0, bk, 1'b0} + {4'd0, idx == 4'd14};
    end
    return l;
  endfunction

  assign loc_a = locate(mode_q, rd_a_idx);
  assign loc_b = locate(mode_q, rd_b_idx);
  assign loc_w = locate(mode_q, wr_idx);
  assign loc_d = locate(dbg_mode, dbg_idx);

  assign rd_a_data = loc_a.ok ? regs[loc_a.slot] : '0;
  assign rd_b_data = loc_b.ok ? regs[loc_b.slot] : '0;
  assign dbg_rdata = loc_d.ok ? regs[loc_d.slot] : '0;
  assign mode_out  = mode_q;
  assign priv      = |mode_q[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= RESET_MODE;
      for (int i = 0; i < NSLOT; i++) regs[i] <= '0;
    end else begin
      if (mode_wr_en) mode_q <= mode_in;
      if (wr_en && loc_w.ok) regs[loc_w.slot] <= wr_data;
      if (dbg_we && loc_d.ok) regs[loc_d.slot] <= dbg_wdata;
    end
  end
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_wr_en,
  input logic [4:0]       mode_in,
  input logic [4:0]       mode_out,
  input logic             priv,
  input logic [3:0]       rd_a_idx,
  input logic [WIDTH-1:0] rd_a_data,
  input logic             wr_en,
  input logic [3:0]       wr_idx,
  input logic [WIDTH-1:0] wr_data,
  input logic [4:0]       dbg_mode,
  input logic [3:0]       dbg_idx,
  input logic             dbg_we,
  input logic [WIDTH-1:0] dbg_rdata
);
  function automatic logic known(input logic [4:0] m);
    return m inside {5'd0, 5'd1, 5'd2, 5'd3, 5'd16, 5'd17, 5'd18, 5'd19, 5'd23, 5'd27};
  endfunction

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr_en |=> mode_out == $past(mode_in)); // R2
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr_en |=> $stable(mode_out)); // R2
  AST_PRIV_USER: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_out == 5'd0 || mode_out == 5'd16) |-> !priv); // R3
  AST_DUMMY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!known(mode_out) && rd_a_idx inside {[4'd8:4'd14]}) |-> rd_a_data == '0); // R8
  AST_DBG_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_mode == mode_out && dbg_idx == rd_a_idx) |-> dbg_rdata == rd_a_data); // R10
  AST_LOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx < 4'd8 && !(dbg_we && dbg_idx == wr_idx))
      |=> (rd_a_idx != $past(wr_idx) || rd_a_data == $past(wr_data))); // R4
endmodule

bind banked_regfile banked_regfile_chk #(.WIDTH(WIDTH)) i_chk (.*);

// File: tb/test_banked_regfile.sv
`timescale 1ns/1ps
module test_banked_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_wr_en = 1'b0;
  logic [4:0]  mode_in = '0;
  logic [4:0]  mode_out;
  logic        priv;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0, dbg_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, dbg_rdata;
  logic        wr_en = 1'b0, dbg_we = 1'b0;
  logic [31:0] wr_data = '0, dbg_wdata = '0;
  logic [4:0]  dbg_mode = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] mem [96];
  logic [4:0]  mmode;

  always #2.5 clk = ~clk;

  banked_regfile i_banked_regfile (.*);

  function automatic int bank(input logic [4:0] m);
    case (m)
      0, 16: return 0;
      1, 17: return 1;
      2, 18: return 2;
      3, 19: return 3;
      23:    return 4;
      27:    return 5;
      default: return -1;
    endcase
  endfunction

  function automatic int owner(input logic [4:0] m, input int idx);
    int b = bank(m);
    if (idx < 8 || idx == 15) return 0;
    if (b < 0) return -1;
    if (idx < 13) return (b == 1) ? 1 : 0;
    return b;
  endfunction

  function automatic logic [31:0] mread(input logic [4:0] m, input int idx);
    int o = owner(m, idx);
    return (o < 0) ? 32'd0 : mem[o*16 + idx];
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input string tag);
    int o;
    #1;
    chk(tag, "rd_a", rd_a_data, mread(mmode, int'(rd_a_idx)));
    chk(tag, "rd_b", rd_b_data, mread(mmode, int'(rd_b_idx)));
    chk(tag, "dbg_rdata", dbg_rdata, mread(dbg_mode, int'(dbg_idx)));
    chk("R2", "mode_out", {27'd0, mode_out}, {27'd0, mmode});
    chk("R3", "priv", {31'd0, priv}, {31'd0, (mmode[0] || mmode[1])});
    @(posedge clk);
    if (wr_en) begin
      o = owner(mmode, int'(wr_idx));
      if (o >= 0) mem[o*16 + int'(wr_idx)] = wr_data;
    end
    if (dbg_we) begin
      o = owner(dbg_mode, int'(dbg_idx));
      if (o >= 0) mem[o*16 + int'(dbg_idx)] = dbg_wdata;
    end
    if (mode_wr_en) mmode = mode_in;
    @(negedge clk);
  endtask

  task automatic wr(input int idx, input logic [31:0] v, input string tag);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_data = v;
    cyc(tag);
    wr_en = 1'b0;
  endtask

  task automatic setmode(input logic [4:0] m, input string tag);
    mode_wr_en = 1'b1; mode_in = m;
    cyc(tag);
    mode_wr_en = 1'b0;
  endtask

  task automatic rdchk(input int idx, input logic [31:0] exp, input string tag);
    rd_a_idx = 4'(idx);
    #1;
    chk(tag, $sformatf("r%0d", idx), rd_a_data, exp);
    cyc(tag);
  endtask

  task automatic dbgchk(input logic [4:0] m, input int idx, input logic [31:0] exp, input string tag);
    dbg_mode = m; dbg_idx = 4'(idx);
    #1;
    chk(tag, $sformatf("dbg m%0d r%0d", m, idx), dbg_rdata, exp);
    cyc(tag);
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #500000;
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 96; i++) mem[i] = '0;
    mmode = 5'd19;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "mode", {27'd0, mode_out}, 32'd19);
    chk("R1", "priv", {31'd0, priv}, 32'd1);
    for (int i = 0; i < 16; i++) rdchk(i, 32'd0, "R1");

    // R4 shared low registers and r15
    wr(3, 32'h33, "R4");
    setmode(5'd0, "R4");  rdchk(3, 32'h33, "R4");
    setmode(5'd1, "R4");  rdchk(3, 32'h33, "R4");
    setmode(5'd9, "R4");  rdchk(3, 32'h33, "R4");
    wr(15, 32'hF15, "R4");
    setmode(5'd0, "R4");  rdchk(15, 32'hF15, "R4");

    // R6 fast-interrupt bank
    wr(8, 32'h08, "R6"); wr(14, 32'h0E, "R6");
    setmode(5'd17, "R6");
    rdchk(8, 32'h0, "R6");
    wr(8, 32'h88, "R6"); wr(14, 32'hEE, "R6");
    rdchk(8, 32'h88, "R6"); rdchk(14, 32'hEE, "R6");
    setmode(5'd16, "R6");
    rdchk(8, 32'h08, "R6"); rdchk(14, 32'h0E, "R6");

    // R7 other privileged banks
    setmode(5'd18, "R7");
    rdchk(8, 32'h08, "R7");
    wr(10, 32'hAA, "R7"); wr(13, 32'hD1, "R7");
    setmode(5'd0, "R7");
    rdchk(10, 32'hAA, "R7"); rdchk(13, 32'h0, "R7");
    setmode(5'd2, "R7");
    rdchk(13, 32'hD1, "R7");

    // R8 empty bank
    setmode(5'd27, "R8"); wr(9, 32'h99, "R8");
    setmode(5'd5, "R8");
    rdchk(9, 32'h0, "R8"); rdchk(14, 32'h0, "R8"); rdchk(3, 32'h33, "R8");
    wr(9, 32'h123, "R8");
    rdchk(9, 32'h0, "R8");
    setmode(5'd0, "R8"); rdchk(9, 32'h99, "R8");

    // R10 debug port
    dbgchk(5'd17, 8, 32'h88, "R10");
    chk("R10", "mode unchanged", {27'd0, mode_out}, 32'd0);
    dbg_we = 1'b1; dbg_mode = 5'd19; dbg_idx = 4'd13; dbg_wdata = 32'h5C;
    cyc("R10"); dbg_we = 1'b0;
    rdchk(13, 32'h0, "R10");
    setmode(5'd19, "R10"); rdchk(13, 32'h5C, "R10");
    dbgchk(5'd19, 13, 32'h5C, "R10");

    // R11 write/debug collision on one physical register
    wr_en = 1'b1; wr_idx = 4'd9; wr_data = 32'h111;
    dbg_we = 1'b1; dbg_mode = 5'd0; dbg_idx = 4'd9; dbg_wdata = 32'h222;
    cyc("R11");
    wr_idx = 4'd11; wr_data = 32'h1; dbg_idx = 4'd12; dbg_wdata = 32'h2;
    cyc("R11");
    wr_en = 1'b0; dbg_we = 1'b0;
    rdchk(9, 32'h222, "R11"); rdchk(11, 32'h1, "R11"); rdchk(12, 32'h2, "R11");

    // R12 write with simultaneous mode change
    wr_en = 1'b1; wr_idx = 4'd14; wr_data = 32'hE19;
    mode_wr_en = 1'b1; mode_in = 5'd18;
    cyc("R12");
    wr_en = 1'b0; mode_wr_en = 1'b0;
    rdchk(14, 32'h0, "R12");
    setmode(5'd19, "R12"); rdchk(14, 32'hE19, "R12");

    // R5 mode code to bank mapping via debug writes to r13
    for (int m = 0; m < 32; m++) begin
      dbg_we = 1'b1; dbg_mode = 5'(m); dbg_idx = 4'd13; dbg_wdata = 32'(m);
      cyc("R5");
    end
    dbg_we = 1'b0;
    dbgchk(5'd0, 13, 32'd16, "R5");  dbgchk(5'd1, 13, 32'd17, "R5");
    dbgchk(5'd2, 13, 32'd18, "R5");  dbgchk(5'd3, 13, 32'd19, "R5");
    dbgchk(5'd23, 13, 32'd23, "R5"); dbgchk(5'd27, 13, 32'd27, "R5");
    dbgchk(5'd5, 13, 32'd0, "R5");   dbgchk(5'd31, 13, 32'd0, "R5");

    // R9 random traffic against the model
    for (int n = 0; n < 600; n++) begin
      automatic logic [4:0] pick[8] = '{5'd0, 5'd17, 5'd18, 5'd19, 5'd23, 5'd27, 5'd6, 5'd30};
      wr_en = 1'($urandom);
      wr_idx = 4'($urandom); wr_data = $urandom;
      dbg_we = ($urandom % 4) == 0;
      dbg_mode = pick[$urandom % 8]; dbg_idx = 4'($urandom); dbg_wdata = $urandom;
      mode_wr_en = ($urandom % 3) == 0; mode_in = pick[$urandom % 8];
      rd_a_idx = 4'($urandom); rd_b_idx = 4'($urandom);
      cyc("R9");
    end
    wr_en = 1'b0; dbg_we = 1'b0; mode_wr_en = 1'b0;
    cyc("R9");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule